// File: doc/BRIEF.md
# NAND Page Transfer Sequencer

This block runs one counted page transfer between a word-wide DMA port and a byte-wide NAND data path. Software picks the direction, the ECC options and single or burst DMA requests in a configuration register. It loads the number of data-area bytes into a count register and then sets a go bit. In the write direction, words taken from the DMA port are split into bytes for the NAND side, least significant byte first. In the read direction, bytes from the NAND side are packed into words for the DMA port.

Every byte that crosses the NAND boundary lowers the count by one. When the count reaches zero, a done event latches into the interrupt status. A second interrupt source reports a rising edge on the synchronized device-ready pin. Enable, raw, masked and write-one-to-clear views cover both sources. The block does not compute ECC. It only emits a pulse to clear the ECC accumulator and a snapshot pulse at each ECC block boundary within the counted bytes. Clearing the go bit in mid-transfer aborts the transfer and empties both holding stages.

Top module: `nand_xfer_seq`

## Requirements
- R1: After `rst`, or after a write of 1 to CTRL bit 2, the registers CTRL, CFG, IEN, RAW and COUNT read zero. Word addresses: 0 CTRL, 1 CFG, 2 STAT, 3 IEN, 4 RAW, 5 MASKED, 6 CLR, 7 COUNT. Read data appears on `reg_rdata` one clock after `reg_addr` is presented.
- R2: With CFG bit 1 = 0 (write direction), each DMA word leaves on `nand_tx_data` as four bytes, least significant first. Bytes go in word order, one per cycle where `nand_tx_valid` and `nand_tx_ready` are both high.
- R3: With CFG bit 1 = 1 (read direction), NAND bytes are packed least significant first into words on `dma_rdata`. A final partial word is delivered once the count reaches zero, and its unfilled bytes are zero.
- R4: COUNT drops by one for each byte moved. Bytes move only while CTRL bit 0 (go) is 1 and COUNT is nonzero. After a transfer of exactly COUNT bytes, COUNT reads 0 and STAT bit 2 (word FIFO not empty) reads 0.
- R5: The byte that takes COUNT from 1 to 0 sets RAW bit 1 (done).
- R6: Writing CTRL bit 0 = 0 while go is set empties the word FIFO and the byte lane, so STAT bits 2 and 1 read 0. No further byte moves, and COUNT keeps its remaining value.
- R7: STAT bit 0 follows `nand_rdy` through a two-stage synchronizer. RAW bit 0 is set only on a rising edge of the synchronized level, so a steady high level does not set it again after a clear.
- R8: Writing CLR clears each RAW bit whose written bit is 1 and leaves the other RAW bits unchanged.
- R9: MASKED reads RAW AND IEN, and `irq` is the OR of the masked bits, registered one clock later.
- R10: In single mode (CFG bit 2 = 0), `dma_req` is high in the write direction when the FIFO has a free slot and COUNT is nonzero, and in the read direction when the FIFO holds a word. In burst mode, the write direction needs BURST free slots. The read direction needs BURST stored words, or any stored word once COUNT is zero.
- R11: With CFG bits 3 and 4 both set, `ecc_snap` pulses once each time the bytes moved since COUNT was loaded reach a multiple of 2^ECC_LOG2. A CTRL write with bit 1 set produces a one-cycle `ecc_clear` pulse.
- R12: The DMA write handshake is refused while the word FIFO is full, and the FIFO is never pushed when full or popped when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| dma_req | output | 1 | DMA service request (single word or burst) |
| dma_wvalid | input | 1 | DMA word offered toward NAND |
| dma_wdata | input | W | DMA word toward NAND |
| dma_wready | output | 1 | Word FIFO accepts the offered word |
| dma_rvalid | output | 1 | Packed word available toward memory |
| dma_rdata | output | W | Packed word toward memory |
| dma_rready | input | 1 | DMA takes the packed word |
| nand_tx_valid | output | 1 | Byte ready for the NAND side |
| nand_tx_data | output | 8 | Byte toward NAND |
| nand_tx_ready | input | 1 | NAND side takes the byte |
| nand_rx_valid | input | 1 | Byte offered by the NAND side |
| nand_rx_data | input | 8 | Byte from NAND |
| nand_rx_ready | output | 1 | Block takes the NAND byte |
| nand_rdy | input | 1 | Asynchronous device-ready pin |
| ecc_clear | output | 1 | One-cycle ECC accumulator clear |
| ecc_snap | output | 1 | One-cycle ECC snapshot at a block boundary |
| irq | output | 1 | Interrupt, OR of enabled raw events |

## Verification
The bench builds the block with an 8-word FIFO, a 12-bit count and ECC_LOG2 = 4. With this 16-byte ECC step, a page of a few dozen bytes already crosses several snapshot boundaries. The shallow FIFO lets the bench reach the full state, and the thresholds just below and at one burst, within a handful of words. Random page lengths up to 150 bytes hit both whole and partial final words in each direction, under random handshake throttling on both sides.

// File: rtl/nts_pkg.sv
`timescale 1ns/1ps
package nts_pkg;
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_CFG   = 3'd1;
  localparam logic [2:0] RA_STAT  = 3'd2;
  localparam logic [2:0] RA_IEN   = 3'd3;
  localparam logic [2:0] RA_IRAW  = 3'd4;
  localparam logic [2:0] RA_IMASK = 3'd5;
  localparam logic [2:0] RA_ICLR  = 3'd6;
  localparam logic [2:0] RA_COUNT = 3'd7;

  localparam int CTRL_GO      = 0;
  localparam int CTRL_ECC_CLR = 1;
  localparam int CTRL_SWRST   = 2;

  localparam int CFG_WIDE    = 0;
  localparam int CFG_RD      = 1;
  localparam int CFG_BURST   = 2;
  localparam int CFG_ECC     = 3;
  localparam int CFG_DMA_ECC = 4;
  localparam int CFG_BITS    = 5;

  localparam int IRQ_RDY  = 0;
  localparam int IRQ_DONE = 1;
  localparam int IRQ_BITS = 2;
endpackage

// File: rtl/nts_word_fifo.sv
`timescale 1ns/1ps
// Word FIFO, DEPTH must be a power of two. Storage has no reset so it maps to RAM.
module nts_word_fifo #(
  parameter  int W     = 32,
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      level <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      level <= level + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    push |-> (level < CW'(DEPTH)));
  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (rst)
    pop |-> (level != '0));
endmodule

// File: rtl/nts_byte_lane.sv
`timescale 1ns/1ps
// One-word holding stage: splits words to bytes (write) or packs bytes to words (read).
module nts_byte_lane #(
  parameter  int W  = 32,
  localparam int NB = W / 8,
  localparam int LW = $clog2(NB + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         rd_mode,
  input  logic         move_en,
  input  logic         count_zero,
  input  logic [W-1:0] src_word,
  input  logic         src_empty,
  output logic         src_pop,
  output logic         snk_push,
  output logic [W-1:0] snk_word,
  input  logic         snk_full,
  output logic         tx_valid,
  output logic [7:0]   tx_data,
  input  logic         tx_ready,
  input  logic         rx_valid,
  input  logic [7:0]   rx_data,
  output logic         rx_ready,
  output logic         byte_fire,
  output logic         holding
);
  logic [W-1:0]  buf_q;
  logic [LW-1:0] lanes_q;
  logic          tx_fire, rx_fire;

  assign tx_valid  = !rd_mode && move_en && (lanes_q != '0);
  assign tx_data   = buf_q[7:0];
  assign src_pop   = !rd_mode && move_en && (lanes_q == '0) && !src_empty;
  assign rx_ready  = rd_mode && move_en && (lanes_q != LW'(NB));
  assign snk_push  = rd_mode && !snk_full &&
                     ((lanes_q == LW'(NB)) || ((lanes_q != '0) && count_zero));
  assign snk_word  = buf_q;
  assign tx_fire   = tx_valid && tx_ready;
  assign rx_fire   = rx_valid && rx_ready;
  assign byte_fire = tx_fire || rx_fire;
  assign holding   = (lanes_q != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      buf_q   <= '0;
      lanes_q <= '0;
    end else if (src_pop) begin
      buf_q   <= src_word;
      lanes_q <= LW'(NB);
    end else if (tx_fire) begin
      buf_q   <= buf_q >> 8;
      lanes_q <= lanes_q - 1'b1;
    end else if (snk_push) begin
      buf_q   <= '0;
      lanes_q <= '0;
    end else if (rx_fire) begin
      for (int b = 0; b < NB; b++) begin
        if (lanes_q == LW'(b)) buf_q[8*b +: 8] <= rx_data;
      end
      lanes_q <= lanes_q + 1'b1;
    end
  end

  assert_lsb_first_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_fire && (lanes_q > LW'(1)) && !flush) |=> (tx_data == $past(buf_q[15:8])));
  assert_push_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
    snk_push |-> (lanes_q != '0));
endmodule

// File: rtl/nts_rdy_sync.sv
`timescale 1ns/1ps
module nts_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign rise  = level && !prev_q;
endmodule

// File: rtl/nand_xfer_seq.sv
`timescale 1ns/1ps
module nand_xfer_seq
  import nts_pkg::*;
#(
  parameter  int W           = 32,
  parameter  int FIFO_DEPTH  = 8,
  parameter  int BURST       = 4,
  parameter  int CNT_W       = 16,
  parameter  int ECC_LOG2    = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int CW          = $clog2(FIFO_DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  output logic         dma_req,
  input  logic         dma_wvalid,
  input  logic [W-1:0] dma_wdata,
  output logic         dma_wready,
  output logic         dma_rvalid,
  output logic [W-1:0] dma_rdata,
  input  logic         dma_rready,
  output logic         nand_tx_valid,
  output logic [7:0]   nand_tx_data,
  input  logic         nand_tx_ready,
  input  logic         nand_rx_valid,
  input  logic [7:0]   nand_rx_data,
  output logic         nand_rx_ready,
  input  logic         nand_rdy,
  output logic         ecc_clear,
  output logic         ecc_snap,
  output logic         irq
);
  logic                go_q;
  logic [CFG_BITS-1:0] cfg_q;
  logic [IRQ_BITS-1:0] ien_q, raw_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ECC_LOG2-1:0] prog_q;

  logic wr_ctrl, wr_cfg, wr_ien, wr_clr, wr_cnt, sw_rst, abort, flush;
  logic rd_mode, burst, count_zero, active;
  logic fifo_push, fifo_pop, lane_pop, lane_push, byte_fire, lane_holding;
  logic [W-1:0]  fifo_rdata, lane_word;
  logic [CW-1:0] fifo_level, fifo_free;
  logic rdy_lvl, rdy_rise, done_evt, snap_evt;
  logic [IRQ_BITS-1:0] clr_mask;
  logic unused_bits;

  assign unused_bits = ^{reg_wdata, cfg_q[CFG_WIDE]};

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_cfg  = reg_we && (reg_addr == RA_CFG);
  assign wr_ien  = reg_we && (reg_addr == RA_IEN);
  assign wr_clr  = reg_we && (reg_addr == RA_ICLR);
  assign wr_cnt  = reg_we && (reg_addr == RA_COUNT);
  assign sw_rst  = wr_ctrl && reg_wdata[CTRL_SWRST];
  assign abort   = wr_ctrl && !reg_wdata[CTRL_GO] && go_q;
  assign flush   = sw_rst || abort;

  assign rd_mode    = cfg_q[CFG_RD];
  assign burst      = cfg_q[CFG_BURST];
  assign count_zero = (cnt_q == '0);
  assign active     = go_q && !count_zero;
  assign fifo_free  = CW'(FIFO_DEPTH) - fifo_level;

  assign dma_wready = go_q && !rd_mode && (fifo_level < CW'(FIFO_DEPTH));
  assign dma_rvalid = rd_mode && (fifo_level != '0);
  assign dma_rdata  = fifo_rdata;
  assign fifo_push  = rd_mode ? lane_push : (dma_wvalid && dma_wready);
  assign fifo_pop   = rd_mode ? (dma_rvalid && dma_rready) : lane_pop;

  always_comb begin
    if (!go_q)
      dma_req = 1'b0;
    else if (rd_mode)
      dma_req = burst ? ((fifo_level >= CW'(BURST)) || (count_zero && fifo_level != '0))
                      : (fifo_level != '0);
    else
      dma_req = !count_zero && (burst ? (fifo_free >= CW'(BURST)) : (fifo_free != '0));
  end

  nts_word_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .push(fifo_push), .wdata(rd_mode ? lane_word : dma_wdata),
    .pop(fifo_pop), .rdata(fifo_rdata), .level(fifo_level)
  );

  nts_byte_lane #(.W(W)) u_lane (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_mode(rd_mode), .move_en(active), .count_zero(count_zero),
    .src_word(fifo_rdata), .src_empty(fifo_level == '0), .src_pop(lane_pop),
    .snk_push(lane_push), .snk_word(lane_word), .snk_full(fifo_level == CW'(FIFO_DEPTH)),
    .tx_valid(nand_tx_valid), .tx_data(nand_tx_data), .tx_ready(nand_tx_ready),
    .rx_valid(nand_rx_valid), .rx_data(nand_rx_data), .rx_ready(nand_rx_ready),
    .byte_fire(byte_fire), .holding(lane_holding)
  );

  nts_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk(clk), .rst(rst), .din(nand_rdy), .level(rdy_lvl), .rise(rdy_rise)
  );

  assign done_evt = byte_fire && !wr_cnt && (cnt_q == CNT_W'(1));
  assign snap_evt = byte_fire && !wr_cnt && cfg_q[CFG_ECC] && cfg_q[CFG_DMA_ECC] && (&prog_q);
  assign clr_mask = wr_clr ? reg_wdata[IRQ_BITS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      go_q      <= 1'b0;
      cfg_q     <= '0;
      ien_q     <= '0;
      raw_q     <= '0;
      cnt_q     <= '0;
      prog_q    <= '0;
      ecc_clear <= 1'b0;
      ecc_snap  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      ecc_clear <= wr_ctrl && reg_wdata[CTRL_ECC_CLR];
      ecc_snap  <= snap_evt;
      irq       <= |(raw_q & ien_q);
      if (wr_ctrl) go_q  <= reg_wdata[CTRL_GO];
      if (wr_cfg)  cfg_q <= reg_wdata[CFG_BITS-1:0];
      if (wr_ien)  ien_q <= reg_wdata[IRQ_BITS-1:0];
      raw_q <= (raw_q & ~clr_mask) | {done_evt, rdy_rise};
      if (wr_cnt) begin
        cnt_q  <= reg_wdata[CNT_W-1:0];
        prog_q <= '0;
      end else if (byte_fire) begin
        cnt_q  <= cnt_q - 1'b1;
        prog_q <= prog_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= 32'(go_q);
        RA_CFG:   reg_rdata <= 32'(cfg_q);
        RA_STAT:  reg_rdata <= 32'({fifo_level != '0, lane_holding, rdy_lvl});
        RA_IEN:   reg_rdata <= 32'(ien_q);
        RA_IRAW:  reg_rdata <= 32'(raw_q);
        RA_IMASK: reg_rdata <= 32'(raw_q & ien_q);
        RA_ICLR:  reg_rdata <= '0;
        default:  reg_rdata <= 32'(cnt_q);
      endcase
    end
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_fire && !wr_cnt && !sw_rst) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_done_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_fire && (cnt_q == CNT_W'(1)) && !wr_cnt && !sw_rst) |=> raw_q[IRQ_DONE]);
  assert_halt_moves_R6: assert property (@(posedge clk) disable iff (rst)
    !go_q |-> !byte_fire);
  assert_rdy_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (rdy_rise && !sw_rst) |=> raw_q[IRQ_RDY]);
  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (rst)
    ((|(raw_q & ien_q)) && !sw_rst) |=> irq);
  assert_burst_rd_R10: assert property (@(posedge clk) disable iff (rst)
    (dma_req && rd_mode && burst) |-> ((fifo_level >= CW'(BURST)) || count_zero));
  assert_burst_wr_R10: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !rd_mode && burst) |-> (fifo_free >= CW'(BURST)));
  assert_full_refuse_R12: assert property (@(posedge clk) disable iff (rst)
    (fifo_level == CW'(FIFO_DEPTH)) |-> !dma_wready);
endmodule

// File: tb/nand_xfer_seq_test.sv
`timescale 1ns/1ps
module nand_xfer_seq_test;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic dma_req, dma_wready, dma_rvalid, nand_tx_valid, nand_rx_ready;
  logic dma_wvalid = 1'b0, dma_rready = 1'b0, nand_tx_ready = 1'b0, nand_rx_valid = 1'b0;
  logic [W-1:0] dma_wdata = '0;
  logic [W-1:0] dma_rdata;
  logic [7:0] nand_tx_data;
  logic [7:0] nand_rx_data = '0;
  logic nand_rdy = 1'b0;
  logic ecc_clear, ecc_snap, irq;

  int checks = 0;
  int errors = 0;
  int snap_cnt = 0;
  logic [7:0]  got_b [0:255];
  logic [31:0] got_w [0:63];

  always #4 clk = ~clk;

  nand_xfer_seq #(.W(W), .FIFO_DEPTH(8), .BURST(4), .CNT_W(12), .ECC_LOG2(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_req(dma_req), .dma_wvalid(dma_wvalid), .dma_wdata(dma_wdata),
    .dma_wready(dma_wready), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
    .dma_rready(dma_rready), .nand_tx_valid(nand_tx_valid), .nand_tx_data(nand_tx_data),
    .nand_tx_ready(nand_tx_ready), .nand_rx_valid(nand_rx_valid), .nand_rx_data(nand_rx_data),
    .nand_rx_ready(nand_rx_ready), .nand_rdy(nand_rdy), .ecc_clear(ecc_clear),
    .ecc_snap(ecc_snap), .irq(irq)
  );

  always @(posedge clk) if (ecc_snap) snap_cnt <= snap_cnt + 1;

  function automatic logic [7:0] pat(int i, int s);
    return 8'(i * 13 + s * 7 + 5);
  endfunction

  function automatic logic [31:0] exp_word(int k, int n, int s);
    logic [31:0] v = '0;
    for (int j = 0; j < 4; j++) if (4 * k + j < n) v[8*j +: 8] = pat(4 * k + j, s);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic feed_dma(int nwords, int s, int n);
    int k = 0;
    while (k < nwords) begin
      @(negedge clk);
      dma_wvalid = 1'b1; dma_wdata = exp_word(k, n, s);
      #1 if (dma_wready) k++;
    end
    @(negedge clk) dma_wvalid = 1'b0;
  endtask

  task automatic sink_nand(int n);
    int g = 0;
    while (g < n) begin
      @(negedge clk);
      nand_tx_ready = ($urandom % 4) != 0;
      #1 if (nand_tx_valid && nand_tx_ready) begin got_b[g] = nand_tx_data; g++; end
    end
    @(negedge clk) nand_tx_ready = 1'b0;
  endtask

  task automatic src_nand(int n, int s);
    int g = 0;
    while (g < n) begin
      @(negedge clk);
      nand_rx_valid = ($urandom % 4) != 0; nand_rx_data = pat(g, s);
      #1 if (nand_rx_valid && nand_rx_ready) g++;
    end
    @(negedge clk) nand_rx_valid = 1'b0;
  endtask

  task automatic sink_dma(int nwords);
    int g = 0;
    while (g < nwords) begin
      @(negedge clk);
      dma_rready = ($urandom % 2) != 0;
      #1 if (dma_rvalid && dma_rready) begin got_w[g] = dma_rdata; g++; end
    end
    @(negedge clk) dma_rready = 1'b0;
  endtask

  task automatic run_xfer(bit rdm, bit bsm, bit eccm, int n);
    logic [31:0] d;
    int s = int'($urandom % 256);
    int nw = (n + 3) / 4;
    int bad = 0;
    int snap0;
    wr(1, 32'({eccm, eccm, bsm, rdm, 1'b0}));
    wr(6, 32'h3);
    wr(7, 32'(n));
    snap0 = snap_cnt;
    wr(0, 32'h1);
    if (!rdm) fork feed_dma(nw, s, n); sink_nand(n); join
    else      fork src_nand(n, s);     sink_dma(nw);  join
    repeat (6) @(negedge clk);
    if (!rdm) begin
      for (int i = 0; i < n; i++) if (got_b[i] !== pat(i, s)) bad++;
      chk("R2 byte order toward NAND", 32'(bad), 0);
    end else begin
      for (int k = 0; k < nw; k++) if (got_w[k] !== exp_word(k, n, s)) bad++;
      chk("R3 packed words toward DMA", 32'(bad), 0);
    end
    rd(7, d); chk("R4 count at end", d, 0);
    rd(2, d); chk("R4 FIFO empty at end", d & 32'h4, 0);
    rd(4, d); chk("R5 done raw bit", d & 32'h2, 32'h2);
    if (eccm) chk("R11 snapshot pulses", 32'(snap_cnt - snap0), 32'(n / 16));
    wr(0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(1, d); chk("R1 CFG after reset", d, 0);
    rd(7, d); chk("R1 COUNT after reset", d, 0);
    rd(4, d); chk("R1 RAW after reset", d, 0);
    rd(0, d); chk("R1 CTRL after reset", d, 0);
    chk("R9 irq low after reset", 32'(irq), 0);

    // directed transfers
    run_xfer(1'b0, 1'b0, 1'b1, 64);
    run_xfer(1'b1, 1'b0, 1'b0, 1);
    run_xfer(1'b1, 1'b1, 1'b1, 38);
    run_xfer(1'b0, 1'b1, 1'b0, 7);
    for (int r = 0; r < 8; r++)
      run_xfer(bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2), 1 + int'($urandom % 150));

    // R8 / R9: raw bit 1 is set from the last transfer
    wr(3, 32'h2);
    rd(5, d); chk("R9 masked view", d, 32'h2);
    repeat (2) @(negedge clk);
    chk("R9 irq with done enabled", 32'(irq), 1);
    wr(3, 32'h0);
    repeat (2) @(negedge clk);
    chk("R9 irq masked off", 32'(irq), 0);

    // R7 ready edge
    nand_rdy = 1'b1;
    repeat (5) @(negedge clk);
    rd(2, d); chk("R7 STAT ready level", d & 32'h1, 1);
    rd(4, d); chk("R7 raw ready edge", d, 32'h3);
    wr(6, 32'h1);
    rd(4, d); chk("R8 clear only bit 0", d, 32'h2);
    repeat (4) @(negedge clk);
    rd(4, d); chk("R7 no retrigger on level", d & 32'h1, 0);
    nand_rdy = 1'b0;

    // R11 ecc clear pulse
    wr(0, 32'h2);
    chk("R11 ecc_clear pulse", 32'(ecc_clear), 1);
    @(negedge clk);
    chk("R11 ecc_clear single cycle", 32'(ecc_clear), 0);

    // R10 request thresholds
    wr(1, 32'h0); wr(7, 32'd8); wr(0, 32'h1);
    chk("R10 single write request", 32'(dma_req), 1);
    wr(0, 32'h0);
    wr(1, 32'h6); wr(7, 32'd32); wr(0, 32'h1);
    src_nand(8, 1);
    repeat (3) @(negedge clk);
    chk("R10 burst read below threshold", 32'(dma_req), 0);
    src_nand(8, 1);
    repeat (3) @(negedge clk);
    chk("R10 burst read at threshold", 32'(dma_req), 1);
    wr(0, 32'h0);

    // R12 / R6 full FIFO then abort
    wr(1, 32'h0); wr(7, 32'd64); wr(0, 32'h1);
    feed_dma(9, 3, 64);
    #1 chk("R12 write refused when full", 32'(dma_wready), 0);
    sink_nand(10);
    rd(7, d); chk("R4 count after ten bytes", d, 54);
    wr(0, 32'h0);
    rd(2, d); chk("R6 both stages empty", d & 32'h6, 0);
    nand_tx_ready = 1'b1;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      #1 if (nand_tx_valid) k++;
    end
    nand_tx_ready = 1'b0;
    chk("R6 no bytes after abort", 32'(k), 0);
    rd(7, d); chk("R6 count kept", d, 54);

    // R1 software reset
    wr(1, 32'h1f); wr(3, 32'h3);
    wr(0, 32'h4);
    rd(1, d); chk("R1 CFG after soft reset", d, 0);
    rd(3, d); chk("R1 IEN after soft reset", d, 0);
    rd(7, d); chk("R1 COUNT after soft reset", d, 0);
    rd(4, d); chk("R1 RAW after soft reset", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule